// File: doc/BRIEF.md
# Capture Time-Base Trigger and Sync Controller

This block drives the time base of an input-capture channel pair. Each channel has a 16-bit control word. The word holds a five-bit event source select, a mode bit that chooses between trigger and sync, a run flag that software can set, and a cascade bit. Event pulses from peer units arrive on a flat 32-bit vector: bit k carries the pulse for select code k. The peer units are timers, capture and compare units, comparators, an ADC-done signal and a charge-measurement unit.

In sync mode a channel's counter free-runs, and the selected event clears it. In trigger mode the counter sits at zero until the selected event, or a software write, sets the run flag. From then on it counts. When both channels have their cascade bit set, the two 16-bit counters form one 32-bit counter. The lower channel's carry steps the upper half, and the lower channel's hold, release and clear act on both halves.

Top module: `cap_tbase_ctrl`

## Requirements
- R1: During and after reset both counters read 0 and both control words read 0x000D: select code 13, sync mode, run flag 0, cascade 0.
- R2: Control word bits are: [8] cascade, [7] mode (1 = trigger), [6] run flag, [4:0] select. Bits 15..9 and bit 5 always read 0, and writing them has no effect. The other fields read back as written, with the run flag subject to R7.
- R3: With select code 0 or a reserved code (6..9, 16..19, 29..31) in sync mode, the counter increments every cycle whatever the pulse vector holds.
- R4: In sync mode, a pulse on the selected source (bit k of the pulse vector for code k) makes the counter read 0 in the next cycle, then 1, 2, ... after that. This holds even when the clear coincides with an increment.
- R5: In trigger mode with the run flag at 0, the counter reads 0. A selected pulse sets the run flag in the next cycle. The counter reads 1 one cycle after the flag is set.
- R6: Writing the run flag as 1 starts the counter in trigger mode without any event, even with select code 0.
- R7: Writing the run flag as 0 stops the counter, which reads 0 one cycle later. A selected pulse in the same cycle as that write wins, and the flag stays 1.
- R8: Codes 24..28 (comparators, ADC, charge unit) start the counter in trigger mode but are treated as no source in sync mode.
- R9: With both cascade bits set, the upper counter steps once each time the lower counter wraps from its maximum to 0. With only one cascade bit set, the two counters run independently.
- R10: While cascaded, the lower channel's sync clear and trigger hold act on both halves in the same cycle.
- R11: Pulses on vector bits other than the selected code have no effect on the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 2 | Write strobe per channel (bit 0 lower, bit 1 upper) |
| ctl_wdata | input | 16 | Control word written on a strobe |
| src_pulse | input | 32 | Peer event pulses, bit k for select code k |
| ctl_rd_lo | output | 16 | Lower channel control word readback |
| ctl_rd_hi | output | 16 | Upper channel control word readback |
| cnt_lo | output | CNT_W | Lower channel counter |
| cnt_hi | output | CNT_W | Upper channel counter |

## Verification
The properties assume that peer pulses and write strobes change only just after a rising edge and stay stable until the next one. They also assume that a pulse lasts one cycle per event. Some properties tie a pulse to a timer select code. For these, the properties take the select value visible on the readback port in the same cycle as the one that acts. The bench changes every input one time unit after the edge and drops pulses after a single cycle. It also never writes a channel in a cycle where a property of that channel depends on an unchanged mode.

// File: rtl/ctb_pkg.sv
package ctb_pkg;
  localparam int SEL_W   = 5;
  localparam int NSRC    = 1 << SEL_W;
  localparam int CTL_W   = 16;
  localparam int B_CASC  = 8;
  localparam int B_TRIG  = 7;
  localparam int B_RUN   = 6;
  localparam logic [CTL_W-1:0] CTL_RST  = 16'h000D;
  localparam logic [CTL_W-1:0] CTL_MASK = 16'h01DF;

  // Legal source codes; trigger-only codes are dropped in sync mode
  function automatic logic code_usable(input logic [SEL_W-1:0] c, input logic trig);
    logic ok;
    ok = 1'b0;
    if (c >= 5'd1  && c <= 5'd5)  ok = 1'b1;
    if (c >= 5'd10 && c <= 5'd15) ok = 1'b1;
    if (c >= 5'd20 && c <= 5'd23) ok = 1'b1;
    if (c >= 5'd24 && c <= 5'd28) ok = trig;
    return ok;
  endfunction
endpackage

// File: rtl/cap_src_dec.sv
module cap_src_dec
  import ctb_pkg::*;
(
  input  logic [SEL_W-1:0] sel,
  input  logic             trig,
  input  logic [NSRC-1:0]  src_pulse,
  output logic             evt
);
  always_comb evt = code_usable(sel, trig) & src_pulse[sel];
endmodule

// File: rtl/cap_ctl_reg.sv
module cap_ctl_reg
  import ctb_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [CTL_W-1:0] wdata,
  input  logic             evt,
  output logic [CTL_W-1:0] ctl_q
);
  logic hw_set;
  assign hw_set = ctl_q[B_TRIG] & evt;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= CTL_RST;
    end else if (wr) begin
      // hardware set outranks a software clear in the same cycle
      ctl_q <= (wdata & CTL_MASK) | (CTL_W'(hw_set) << B_RUN);
    end else if (hw_set) begin
      ctl_q[B_RUN] <= 1'b1;
    end
  end
endmodule

// File: rtl/cap_cnt.sv
module cap_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         zero,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (zero) cnt <= '0;
    else if (inc)  cnt <= cnt + W'(1);
  end
endmodule

// File: rtl/cap_tbase_ctrl.sv
module cap_tbase_ctrl
  import ctb_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       ctl_wr,
  input  logic [CTL_W-1:0] ctl_wdata,
  input  logic [NSRC-1:0]  src_pulse,
  output logic [CTL_W-1:0] ctl_rd_lo,
  output logic [CTL_W-1:0] ctl_rd_hi,
  output logic [CNT_W-1:0] cnt_lo,
  output logic [CNT_W-1:0] cnt_hi
);
  localparam int NCH = 2;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CTL_W-1:0] ctl   [NCH];
  logic [CNT_W-1:0] cnt   [NCH];
  logic [NCH-1:0]   evt;
  logic [NCH-1:0]   zero_own;
  logic [NCH-1:0]   zero_eff;
  logic [NCH-1:0]   inc_eff;
  logic             casc_on;
  logic             carry_lo;

  assign casc_on  = ctl[0][B_CASC] & ctl[1][B_CASC];
  assign carry_lo = ~zero_own[0] & (cnt[0] == CNT_MAX);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    cap_src_dec u_dec (
      .sel       (ctl[i][SEL_W-1:0]),
      .trig      (ctl[i][B_TRIG]),
      .src_pulse (src_pulse),
      .evt       (evt[i])
    );

    cap_ctl_reg u_reg (
      .clk   (clk),
      .rst   (rst),
      .wr    (ctl_wr[i]),
      .wdata (ctl_wdata),
      .evt   (evt[i]),
      .ctl_q (ctl[i])
    );

    // trigger mode: held while not running; sync mode: cleared by event
    assign zero_own[i] = ctl[i][B_TRIG] ? ~ctl[i][B_RUN] : evt[i];

    if (i == 0) begin : g_lower
      assign zero_eff[i] = zero_own[i];
      assign inc_eff[i]  = 1'b1;
    end else begin : g_upper
      assign zero_eff[i] = casc_on ? zero_own[0] : zero_own[i];
      assign inc_eff[i]  = casc_on ? carry_lo    : 1'b1;
    end

    cap_cnt #(.W(CNT_W)) u_cnt (
      .clk  (clk),
      .rst  (rst),
      .zero (zero_eff[i]),
      .inc  (inc_eff[i]),
      .cnt  (cnt[i])
    );
  end

  assign ctl_rd_lo = ctl[0];
  assign ctl_rd_hi = ctl[1];
  assign cnt_lo    = cnt[0];
  assign cnt_hi    = cnt[1];
endmodule

// File: rtl/cap_tbase_chk.sv
module cap_tbase_chk
  import ctb_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       ctl_wr,
  input logic [NSRC-1:0]  src_pulse,
  input logic [CTL_W-1:0] ctl_rd_lo,
  input logic [CTL_W-1:0] ctl_rd_hi,
  input logic [CNT_W-1:0] cnt_lo,
  input logic [CNT_W-1:0] cnt_hi
);
  logic timer_sel_lo;
  logic sel_hit_lo;
  logic both_casc;
  assign timer_sel_lo = (ctl_rd_lo[4:0] >= 5'd11) && (ctl_rd_lo[4:0] <= 5'd15);
  assign sel_hit_lo   = src_pulse[ctl_rd_lo[4:0]];
  assign both_casc    = ctl_rd_lo[B_CASC] && ctl_rd_hi[B_CASC];

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (cnt_lo == '0 && cnt_hi == '0 && ctl_rd_lo == CTL_RST && ctl_rd_hi == CTL_RST));

  assert_reserved_bits_R2: assert property (@(posedge clk) disable iff (rst)
    (ctl_rd_lo[15:9] == 7'd0 && ctl_rd_lo[5] == 1'b0 &&
     ctl_rd_hi[15:9] == 7'd0 && ctl_rd_hi[5] == 1'b0));

  assert_free_run_R3: assert property (@(posedge clk) disable iff (rst)
    (!ctl_rd_lo[B_TRIG] && ctl_rd_lo[4:0] == 5'd0) |=> cnt_lo == $past(cnt_lo) + CNT_W'(1));

  assert_sync_clear_R4: assert property (@(posedge clk) disable iff (rst)
    (!ctl_rd_lo[B_TRIG] && timer_sel_lo && sel_hit_lo) |=> cnt_lo == '0);

  assert_held_R5: assert property (@(posedge clk) disable iff (rst)
    (ctl_rd_lo[B_TRIG] && !ctl_rd_lo[B_RUN]) |=> cnt_lo == '0);

  assert_hw_set_R7: assert property (@(posedge clk) disable iff (rst)
    (ctl_rd_lo[B_TRIG] && timer_sel_lo && sel_hit_lo) |=> ctl_rd_lo[B_RUN]);

  assert_cascade_step_R9: assert property (@(posedge clk) disable iff (rst)
    (both_casc && ctl_rd_lo[B_TRIG] && ctl_rd_lo[B_RUN] && cnt_lo == {CNT_W{1'b1}} && ctl_wr == 2'b00)
    |=> cnt_hi == $past(cnt_hi) + CNT_W'(1));

  assert_cascade_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (both_casc && ctl_rd_lo[B_TRIG] && !ctl_rd_lo[B_RUN]) |=> cnt_hi == '0);
endmodule

bind cap_tbase_ctrl cap_tbase_chk #(.CNT_W(CNT_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .ctl_wr    (ctl_wr),
  .src_pulse (src_pulse),
  .ctl_rd_lo (ctl_rd_lo),
  .ctl_rd_hi (ctl_rd_hi),
  .cnt_lo    (cnt_lo),
  .cnt_hi    (cnt_hi)
);

// File: tb/cap_tbase_ctrl_tb_top.sv
module cap_tbase_ctrl_tb_top;
  localparam int W = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    ctl_wr = 2'b00;
  logic [15:0]   ctl_wdata = 16'h0;
  logic [31:0]   src_pulse = 32'h0;
  logic [15:0]   ctl_rd_lo, ctl_rd_hi;
  logic [W-1:0]  cnt_lo, cnt_hi;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct {
    string       req;
    int          sig;
    logic [31:0] exp;
  } item_t;
  item_t exp_q[$];

  always #4 clk = ~clk;

  cap_tbase_ctrl #(.CNT_W(W)) dut_i (
    .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .src_pulse(src_pulse), .ctl_rd_lo(ctl_rd_lo), .ctl_rd_hi(ctl_rd_hi),
    .cnt_lo(cnt_lo), .cnt_hi(cnt_hi)
  );

  function automatic logic [31:0] pick(input int s);
    case (s)
      0: return 32'(cnt_lo);
      1: return 32'(cnt_hi);
      2: return 32'(ctl_rd_lo);
      default: return 32'(ctl_rd_hi);
    endcase
  endfunction

  // monitor: pop and compare away from the active edge
  always @(negedge clk) begin
    while (exp_q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = exp_q.pop_front();
      act = pick(it.sig);
      checks++;
      if (act !== it.exp) begin
        failures++;
        $display("FAIL %s sig=%0d actual=0x%0h expected=0x%0h", it.req, it.sig, act, it.exp);
      end
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic push(input string r, input int s, input logic [31:0] e);
    item_t it;
    it.req = r; it.sig = s; it.exp = e;
    exp_q.push_back(it);
  endtask

  task automatic wr(input int ch, input logic [15:0] d);
    ctl_wr = (ch == 0) ? 2'b01 : 2'b10;
    ctl_wdata = d;
    step();
    ctl_wr = 2'b00;
  endtask

  task automatic pulse(input logic [31:0] v);
    src_pulse = v;
    step();
    src_pulse = 32'h0;
  endtask

  function automatic logic [31:0] nxt(input logic [W-1:0] c);
    return 32'(W'(c + W'(1)));
  endfunction

  initial begin
    logic [W-1:0] c;
    // R1 reset state
    repeat (3) step();
    push("R1", 0, 0); push("R1", 1, 0);
    push("R1", 2, 32'h000D); push("R1", 3, 32'h000D);
    rst = 1'b0;
    step();
    // R2 reserved bits read zero; upper alone in trigger+run
    wr(1, 16'hFFFF);
    push("R2", 3, 32'h01DF);
    step();
    // R9 single cascade bit: upper runs on its own
    c = cnt_hi;
    step();
    push("R9", 1, nxt(c));
    // R4 sync clear with timer 3 (bit 13)
    pulse(32'h1 << 13);
    push("R4", 0, 0);
    step(); push("R4", 0, 1);
    step(); push("R4", 0, 2);
    // R11 all other bits pulse: no clear
    c = cnt_lo;
    pulse(~(32'h1 << 13));
    push("R11", 0, nxt(c));
    // R3 code 0 and reserved code 9
    wr(0, 16'h0000);
    c = cnt_lo;
    pulse(32'hFFFF_FFFF);
    push("R3", 0, nxt(c));
    wr(0, 16'h0009);
    c = cnt_lo;
    pulse(32'hFFFF_FFFF);
    push("R3", 0, nxt(c));
    // R8 trigger-only codes ignored in sync mode
    wr(0, 16'h0018);
    c = cnt_lo;
    pulse(32'h1 << 24);
    push("R8", 0, nxt(c));
    wr(0, 16'h001C);
    c = cnt_lo;
    pulse(32'h1 << 28);
    push("R8", 0, nxt(c));
    // R5 trigger from timer 1 (bit 11)
    wr(0, 16'h008B);
    push("R5", 2, 32'h008B);
    step(); push("R5", 0, 0);
    step(); step(); push("R5", 0, 0); push("R5", 2, 32'h008B);
    pulse(32'h1 << 11);
    push("R5", 2, 32'h00CB); push("R5", 0, 0);
    step(); push("R5", 0, 1);
    step(); push("R5", 0, 2);
    // R7 software clear, then hw set beats sw clear
    wr(0, 16'h008B);
    push("R7", 2, 32'h008B);
    step(); push("R7", 0, 0);
    src_pulse = 32'h1 << 11;
    wr(0, 16'h008B);
    src_pulse = 32'h0;
    push("R7", 2, 32'h00CB);
    // R6 software start with no source
    wr(0, 16'h0080);
    step();
    wr(0, 16'h00C0);
    push("R6", 2, 32'h00C0); push("R6", 0, 0);
    step(); push("R6", 0, 1);
    // R8 comparator code starts in trigger mode
    wr(0, 16'h0098);
    step(); push("R8", 0, 0);
    pulse(32'h1 << 24);
    push("R8", 2, 32'h00D8);
    step(); push("R8", 0, 1);
    // R9/R10 cascade in sync mode
    wr(1, 16'h0100);
    wr(0, 16'h010D);
    pulse(32'h1 << 13);
    push("R10", 0, 0); push("R10", 1, 0);
    repeat (255) step();
    push("R9", 0, 255); push("R9", 1, 0);
    step(); push("R9", 0, 0); push("R9", 1, 1);
    // R10 cascade in trigger mode: both held, both released
    wr(0, 16'h018D);
    step(); push("R10", 0, 0); push("R10", 1, 0);
    step(); push("R10", 1, 0);
    pulse(32'h1 << 13);
    push("R10", 2, 32'h01CD); push("R10", 0, 0); push("R10", 1, 0);
    repeat (300) step();
    push("R10", 0, 44); push("R10", 1, 1);
    step(); step();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule